// File: doc/BRIEF.md
# Telecom Clock Mode and Frame Generator

This block holds the timing-mode configuration of a TDM backplane port and produces its digital timing. A free-running 11-bit counter on the master clock (nominally 16.384 MHz) produces local clocks at one half, one quarter and one eighth of that rate (8.192, 4.096 and 2.048 MHz). Each local clock has its own polarity control. The same counter produces an active-low 8 kHz frame pulse. An 8-bit control word decides three things: which reference the external analog PLL should lock to, which 8 kHz input feeds the digital PLL, and whether the counter stays free-running or re-aligns to the backplane's incoming frame pulse.

The block does not contain the PLLs. It only emits select codes for them. A separate 2-bit field with its own enable picks the 8 kHz signal that is exported on a secondary reference pin. In the bus-slave mode, a frame pulse that arrives at the wrong count re-aligns the counter and latches an error flag. Any later register write clears that flag.

Top module: `tcf_top`

## Requirements
- R1: After reset `cfg_q` is 0x00, `apll_ref` is 0, `xtal_div` is 0, `dpll_src` is 0, `bus_master` is 1, `sec8k_oe` is 0, `frame_err` is 0, and the frame counter is at 0, so `frame_n` is low.
- R2: The frame counter advances by one each clock and wraps after 2048 counts. `frame_n` is low at counts 2046, 2047, 0 and 1 and high at all other counts, which gives a low pulse of 4 clocks every 2048 clocks.
- R3: `clk8_o`, `clk4_o` and `clk2_o` equal the inverse of counter bits 0, 1 and 2 respectively. Each is XORed with `clk_inv[0]`, `clk_inv[1]` and `clk_inv[2]`, so with the inversion bit at 0 each clock is high while its counter bit is 0.
- R4: The control word is laid out as bits [1:0] crystal select, bits [4:2] mode, bit 5 export enable and bits [7:6] export source. In mode 0, `apll_ref` is 0 (divided crystal). Crystal select 01 gives `xtal_div` 1 (divide by 2), 10 gives 2 (divide by 1), and 00 or 11 gives 0 (divide by 4).
- R5: In modes 1, 2 and 3, `apll_ref` is 1 (digital PLL), `dpll_src` equals the mode number (1 secondary reference pin, 2 external input A, 3 external input B), `xtal_div` is forced to 0 whatever the crystal select is, and `bus_master` is 1.
- R6: In mode 4, `apll_ref` is 2 (bus 4.096 MHz clock), `dpll_src` is 0 and `bus_master` is 0. A falling edge of `bus_f0_n` seen while the counter is at 2046 leaves the count sequence and `frame_err` unchanged. A falling edge seen at any other count makes the counter 2047 after that clock and sets `frame_err`. Counting then continues from 2047.
- R7: In every mode other than 4, `bus_f0_n` has no effect on the frame timing or on `frame_err`.
- R8: Mode codes 5, 6 and 7 give the same `apll_ref`, `xtal_div`, `dpll_src` and `bus_master` as mode 0.
- R9: `frame_err` stays set until a register write clears it. If a write and a misaligned frame pulse fall in the same clock, `frame_err` ends up set.
- R10: `sec8k_oe` equals the export enable bit. While it is 1, `sec8k_o` carries `ext8k_a` for source 00, `ext8k_b` for 01 and `frame_n` for 10, and is constant 0 for 11. While the enable bit is 0, `sec8k_o` is 0.
- R11: A write with `cfg_wr` high takes effect at the next clock edge, and `cfg_q` then reads back the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| clk_inv | input | 3 | Polarity inversion for the 8.192, 4.096 and 2.048 MHz clocks |
| bus_f0_n | input | 1 | Incoming backplane frame pulse, active low |
| ext8k_a | input | 1 | External 8 kHz input A |
| ext8k_b | input | 1 | External 8 kHz input B |
| cfg_q | output | 8 | Control word readback |
| apll_ref | output | 2 | Analog PLL reference select: 0 crystal, 1 digital PLL, 2 bus clock |
| xtal_div | output | 2 | Crystal divider select: 0 by 4, 1 by 2, 2 by 1 |
| dpll_src | output | 2 | Digital PLL input select: 0 none, 1 secondary pin, 2 input A, 3 input B |
| bus_master | output | 1 | High when the port drives backplane timing |
| frame_n | output | 1 | Local 8 kHz frame pulse, active low |
| clk8_o | output | 1 | 8.192 MHz local clock |
| clk4_o | output | 1 | 4.096 MHz local clock |
| clk2_o | output | 1 | 2.048 MHz local clock |
| sec8k_o | output | 1 | Exported 8 kHz reference |
| sec8k_oe | output | 1 | Output enable for the exported reference |
| frame_err | output | 1 | Sticky misaligned-frame flag |

## Verification
The error flag has two writers. A misaligned incoming frame pulse in mode 4 sets it, and a register write clears it, so both can act in the same clock. The bench first leaves the flag set from an earlier misaligned pulse. It then drives a register write and a new off-count falling edge of `bus_f0_n` into the same edge, and expects the flag to stay set and the counter to be reloaded. A plain write in a later clock must then clear the flag.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  localparam int CFG_W = 8;

  typedef struct packed {
    logic [1:0] exp_src;
    logic       exp_en;
    logic [2:0] mode;
    logic [1:0] xsel;
  } tcf_cfg_t;

  typedef enum logic [1:0] {
    REF_XTAL = 2'd0,
    REF_DPLL = 2'd1,
    REF_BUS  = 2'd2
  } tcf_ref_e;

  localparam logic [2:0] MODE_MASTER = 3'd0;
  localparam logic [2:0] MODE_SLAVE  = 3'd4;

  // modes above the slave code fall back to the master mode
  function automatic logic [2:0] eff_mode(input logic [2:0] raw);
    return (raw > MODE_SLAVE) ? MODE_MASTER : raw;
  endfunction

  // crystal select to divider code; 11 is treated as the default
  function automatic logic [1:0] xdiv_code(input logic [1:0] xsel);
    case (xsel)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // true while the frame pulse is active, window straddles the wrap
  function automatic logic frame_active(input int unsigned c,
                                        input int unsigned len,
                                        input int unsigned half);
    return (c >= len - half) || (c < half);
  endfunction

endpackage

// File: rtl/tcf_mode_dec.sv
module tcf_mode_dec
  import tcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output tcf_cfg_t         cfg,
  output logic [1:0]       apll_ref,
  output logic [1:0]       xtal_div,
  output logic [1:0]       dpll_src,
  output logic             bus_master,
  output logic             slave_en
);

  logic [2:0] mode_e;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= tcf_cfg_t'(cfg_wdata);
  end

  assign mode_e = eff_mode(cfg.mode);

  always_comb begin
    apll_ref   = REF_XTAL;
    xtal_div   = 2'd0;
    dpll_src   = 2'd0;
    bus_master = 1'b1;
    slave_en   = 1'b0;
    case (mode_e)
      3'd1, 3'd2, 3'd3: begin
        apll_ref = REF_DPLL;
        dpll_src = mode_e[1:0];
      end
      MODE_SLAVE: begin
        apll_ref   = REF_BUS;
        bus_master = 1'b0;
        slave_en   = 1'b1;
      end
      default: begin
        xtal_div = xdiv_code(cfg.xsel);
      end
    endcase
  end

endmodule

// File: rtl/tcf_frame_ctr.sv
module tcf_frame_ctr
  import tcf_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic             f0_n,
  input  logic             cfg_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_n,
  output logic             resync_evt,
  output logic             err_set,
  output logic             frame_err
);

  localparam int unsigned   LEN    = 1 << CNT_W;
  localparam logic [CNT_W-1:0] ALIGN_V = CNT_W'(LEN - HALF);
  localparam logic [CNT_W-1:0] LOAD_V  = CNT_W'(LEN - HALF + 1);

  logic f0_d;
  logic f0_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) f0_d <= 1'b1;
    else        f0_d <= f0_n;
  end

  assign f0_fall    = f0_d & ~f0_n;
  assign resync_evt = slave_en & f0_fall;
  assign err_set    = resync_evt & (cnt != ALIGN_V);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (resync_evt) cnt <= LOAD_V;
    else                 cnt <= cnt + 1'b1;
  end

  // a fresh error outranks the clear from a write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)       frame_err <= 1'b0;
    else if (err_set) frame_err <= 1'b1;
    else if (cfg_wr)  frame_err <= 1'b0;
  end

  assign frame_n = ~frame_active(32'(cnt), LEN, HALF);

endmodule

// File: rtl/tcf_clk_out.sv
module tcf_clk_out #(
  parameter int NCLK = 3
) (
  input  logic [NCLK-1:0] taps,
  input  logic [NCLK-1:0] inv,
  output logic [NCLK-1:0] lclk
);

  for (genvar i = 0; i < NCLK; i++) begin : g_clk
    assign lclk[i] = ~taps[i] ^ inv[i];
  end

endmodule

// File: rtl/tcf_sec_mux.sv
module tcf_sec_mux (
  input  logic       en,
  input  logic [1:0] src,
  input  logic       ext_a,
  input  logic       ext_b,
  input  logic       frame_n,
  output logic       sec_o,
  output logic       sec_oe
);

  logic pick;

  always_comb begin
    case (src)
      2'b00:   pick = ext_a;
      2'b01:   pick = ext_b;
      2'b10:   pick = frame_n;
      default: pick = 1'b0;
    endcase
  end

  assign sec_o  = en & pick;
  assign sec_oe = en;

endmodule

// File: rtl/tcf_top.sv
module tcf_top
  import tcf_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int HALF  = 2,
  parameter int NCLK  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NCLK-1:0]  clk_inv,
  input  logic             bus_f0_n,
  input  logic             ext8k_a,
  input  logic             ext8k_b,
  output logic [CFG_W-1:0] cfg_q,
  output logic [1:0]       apll_ref,
  output logic [1:0]       xtal_div,
  output logic [1:0]       dpll_src,
  output logic             bus_master,
  output logic             frame_n,
  output logic             clk8_o,
  output logic             clk4_o,
  output logic             clk2_o,
  output logic             sec8k_o,
  output logic             sec8k_oe,
  output logic             frame_err
);

  tcf_cfg_t         cfg;
  logic             slave_en;
  logic [CNT_W-1:0] frame_cnt;
  logic             resync_evt;
  logic             err_set;
  logic [NCLK-1:0]  lclk;

  tcf_mode_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg        (cfg),
    .apll_ref   (apll_ref),
    .xtal_div   (xtal_div),
    .dpll_src   (dpll_src),
    .bus_master (bus_master),
    .slave_en   (slave_en)
  );

  tcf_frame_ctr #(.CNT_W(CNT_W), .HALF(HALF)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_en   (slave_en),
    .f0_n       (bus_f0_n),
    .cfg_wr     (cfg_wr),
    .cnt        (frame_cnt),
    .frame_n    (frame_n),
    .resync_evt (resync_evt),
    .err_set    (err_set),
    .frame_err  (frame_err)
  );

  tcf_clk_out #(.NCLK(NCLK)) u_clk (
    .taps (frame_cnt[NCLK-1:0]),
    .inv  (clk_inv),
    .lclk (lclk)
  );

  tcf_sec_mux u_sec (
    .en      (cfg.exp_en),
    .src     (cfg.exp_src),
    .ext_a   (ext8k_a),
    .ext_b   (ext8k_b),
    .frame_n (frame_n),
    .sec_o   (sec8k_o),
    .sec_oe  (sec8k_oe)
  );

  assign cfg_q  = cfg;
  assign clk8_o = lclk[0];
  assign clk4_o = lclk[1];
  assign clk2_o = lclk[2];

endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
  parameter int CNT_W = 11,
  parameter int HALF  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [7:0]       cfg_q,
  input logic             bus_master,
  input logic [1:0]       apll_ref,
  input logic             frame_n,
  input logic             clk8_o,
  input logic             clk_inv0,
  input logic             sec8k_o,
  input logic             sec8k_oe,
  input logic             frame_err,
  input logic [CNT_W-1:0] cnt,
  input logic             resync_evt,
  input logic             err_set
);

  localparam int unsigned LEN = 1 << CNT_W;

  assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_evt |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (!$past(resync_evt) && cnt == CNT_W'(LEN - HALF)) || $past(resync_evt));

  assert_clk8_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync_evt && !cfg_wr) ##1 $stable(clk_inv0) |-> clk8_o != $past(clk8_o));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |=> cnt == CNT_W'(LEN - HALF + 1));

  assert_slave_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |-> (cfg_q[4:2] == 3'd4 && !bus_master && apll_ref == 2'd2));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !cfg_wr) |=> frame_err);

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> frame_err);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !err_set) |=> !frame_err);

  assert_sec_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sec8k_oe |-> !sec8k_o);

endmodule

bind tcf_top tcf_checker #(.CNT_W(CNT_W), .HALF(HALF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_q      (cfg_q),
  .bus_master (bus_master),
  .apll_ref   (apll_ref),
  .frame_n    (frame_n),
  .clk8_o     (clk8_o),
  .clk_inv0   (clk_inv[0]),
  .sec8k_o    (sec8k_o),
  .sec8k_oe   (sec8k_oe),
  .frame_err  (frame_err),
  .cnt        (frame_cnt),
  .resync_evt (resync_evt),
  .err_set    (err_set)
);

// File: tb/tcf_top_tb.sv
module tcf_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [2:0] clk_inv = 3'b000;
  logic       bus_f0_n = 1'b1;
  logic       ext8k_a = 1'b0;
  logic       ext8k_b = 1'b0;
  logic [7:0] cfg_q;
  logic [1:0] apll_ref, xtal_div, dpll_src;
  logic       bus_master, frame_n, clk8_o, clk4_o, clk2_o;
  logic       sec8k_o, sec8k_oe, frame_err;

  int nchk = 0;
  int nerr = 0;
  int ecnt = 0;

  always #4 clk = ~clk;

  tcf_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .clk_inv(clk_inv), .bus_f0_n(bus_f0_n), .ext8k_a(ext8k_a),
    .ext8k_b(ext8k_b), .cfg_q(cfg_q), .apll_ref(apll_ref),
    .xtal_div(xtal_div), .dpll_src(dpll_src), .bus_master(bus_master),
    .frame_n(frame_n), .clk8_o(clk8_o), .clk4_o(clk4_o), .clk2_o(clk2_o),
    .sec8k_o(sec8k_o), .sec8k_oe(sec8k_oe), .frame_err(frame_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock; the expected count follows the free-running rule
  task automatic tick();
    logic r;
    r = rst_n;
    @(posedge clk);
    ecnt = r ? (ecnt + 1) % 2048 : 0;
    #2;
  endtask

  function automatic logic exp_frame(input int c);
    return !((c >= 2046) || (c < 2));
  endfunction

  task automatic cfg_write(input logic [7:0] d);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic run_frames(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (frame_n !== exp_frame(ecnt)) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 cfg_q", cfg_q, 8'h00);
    chk("R1 apll_ref", apll_ref, 0);
    chk("R1 xtal_div", xtal_div, 0);
    chk("R1 dpll_src", dpll_src, 0);
    chk("R1 bus_master", bus_master, 1);
    chk("R1 sec8k_oe", sec8k_oe, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 frame_n", frame_n, 0);
  endtask

  task automatic t_frame();
    run_frames(4200, "R2 frame window");
  endtask

  task automatic t_clocks();
    int bad = 0;
    for (int k = 0; k < 2; k++) begin
      clk_inv = (k == 0) ? 3'b000 : 3'b101;
      for (int i = 0; i < 20; i++) begin
        tick();
        if (clk8_o !== (~ecnt[0] ^ clk_inv[0])) bad++;
        if (clk4_o !== (~ecnt[1] ^ clk_inv[1])) bad++;
        if (clk2_o !== (~ecnt[2] ^ clk_inv[2])) bad++;
      end
    end
    clk_inv = 3'b000;
    chk("R3 local clocks", bad, 0);
  endtask

  task automatic t_write();
    cfg_wr = 1'b1;
    cfg_wdata = 8'h02;
    #1;
    chk("R11 before edge", cfg_q, 8'h00);
    tick();
    cfg_wr = 1'b0;
    chk("R11 readback", cfg_q, 8'h02);
  endtask

  task automatic t_xtal();
    logic [1:0] ex [4] = '{2'd0, 2'd1, 2'd2, 2'd0};
    for (int s = 0; s < 4; s++) begin
      cfg_write(8'(s));
      chk("R4 xtal_div", xtal_div, ex[s]);
      chk("R4 apll_ref", apll_ref, 0);
    end
  endtask

  task automatic t_dpll();
    for (int m = 1; m <= 3; m++) begin
      cfg_write(8'((m << 2) | 2));
      chk("R5 apll_ref", apll_ref, 1);
      chk("R5 dpll_src", dpll_src, m);
      chk("R5 xtal_div forced", xtal_div, 0);
      chk("R5 bus_master", bus_master, 1);
    end
  endtask

  task automatic t_high_modes();
    for (int m = 5; m <= 7; m++) begin
      cfg_write(8'((m << 2) | 1));
      chk("R8 apll_ref", apll_ref, 0);
      chk("R8 xtal_div", xtal_div, 1);
      chk("R8 dpll_src", dpll_src, 0);
      chk("R8 bus_master", bus_master, 1);
    end
  endtask

  task automatic f0_pulse_ignored(input logic [7:0] word, input string tag);
    cfg_write(word);
    while (ecnt != 700) tick();
    bus_f0_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (i == 0) chk(tag, frame_n, exp_frame(ecnt));
    end
    bus_f0_n = 1'b1;
    run_frames(2100, tag);
    chk(tag, frame_err, 0);
  endtask

  task automatic t_ignore();
    f0_pulse_ignored(8'h08, "R7 mode2 F0");
    f0_pulse_ignored(8'h00, "R7 mode0 F0");
    f0_pulse_ignored(8'h18, "R7 mode6 F0");
  endtask

  task automatic t_slave();
    cfg_write(8'h10);
    chk("R6 apll_ref", apll_ref, 2);
    chk("R6 bus_master", bus_master, 0);
    chk("R6 dpll_src", dpll_src, 0);
    while (ecnt != 2046) tick();
    bus_f0_n = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    bus_f0_n = 1'b1;
    chk("R6 aligned no err", frame_err, 0);
    run_frames(100, "R6 aligned timing");
    while (ecnt != 500) tick();
    bus_f0_n = 1'b0;
    tick();
    ecnt = 2047;
    chk("R6 reload frame_n", frame_n, 0);
    chk("R6 err set", frame_err, 1);
    for (int i = 0; i < 3; i++) tick();
    bus_f0_n = 1'b1;
    run_frames(2100, "R6 realigned timing");
    chk("R9 err sticky", frame_err, 1);
  endtask

  task automatic t_collide();
    while (ecnt != 300) tick();
    bus_f0_n = 1'b0;
    cfg_wr = 1'b1;
    cfg_wdata = 8'h10;
    tick();
    cfg_wr = 1'b0;
    ecnt = 2047;
    chk("R9 set beats clear", frame_err, 1);
    chk("R9 reload on collision", frame_n, 0);
    tick();
    bus_f0_n = 1'b1;
    tick();
    cfg_write(8'h10);
    chk("R9 write clears", frame_err, 0);
    run_frames(50, "R9 timing after collision");
  endtask

  task automatic t_sec();
    cfg_write(8'h00);
    ext8k_a = 1'b1;
    ext8k_b = 1'b1;
    #1;
    chk("R10 disabled oe", sec8k_oe, 0);
    chk("R10 disabled out", sec8k_o, 0);
    cfg_write(8'h20);
    chk("R10 oe", sec8k_oe, 1);
    chk("R10 src A high", sec8k_o, 1);
    ext8k_a = 1'b0;
    #1;
    chk("R10 src A low", sec8k_o, 0);
    cfg_write(8'h60);
    chk("R10 src B high", sec8k_o, 1);
    ext8k_b = 1'b0;
    #1;
    chk("R10 src B low", sec8k_o, 0);
    cfg_write(8'hA0);
    begin
      int bad = 0;
      for (int i = 0; i < 2100; i++) begin
        tick();
        if (sec8k_o !== exp_frame(ecnt)) bad++;
      end
      chk("R10 src frame", bad, 0);
    end
    ext8k_a = 1'b1;
    ext8k_b = 1'b1;
    cfg_write(8'hE0);
    chk("R10 reserved low", sec8k_o, 0);
    chk("R10 reserved oe", sec8k_oe, 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tick();
    t_reset();
    rst_n = 1'b1;
    t_frame();
    t_clocks();
    t_write();
    t_xtal();
    t_dpll();
    t_high_modes();
    t_ignore();
    t_slave();
    t_collide();
    t_sec();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule